// File: doc/BRIEF.md
# Discharge-Cycle Measurement Sequencer

This block is a clocked controller that measures an RC time constant in units of its own clock period. It drives three switch enables to an analog storage node: a clear switch, a charge switch fed by a constant current, and a discharge switch that drains the node through the resistance under test. An external voltage-to-pulse converter, started by a one-cycle trigger, answers with an enable pulse. The pulse is longer when the node voltage is lower. The sequencer measures that pulse with an internal gated counter.

A measurement runs in two phases. First the node is cleared and charged for a programmed number of cycles, and the quantized pulse code is kept as the reference. The node is then cleared again and charged for exactly twice that time, which doubles the voltage. After that the sequencer loops: it quantizes, compares the new code with the reference, and while the new code is smaller it closes the discharge switch for one clock and counts that pulse. The loop stops when the voltage has fallen back to the first level. The pulse count is then proportional to the time constant.

Software loads the clear length, the charge length and the settle time with each start, then waits for the done pulse and reads the count.

Top module: `tau_meas_seq`

## Requirements
- R1: While and after reset, all switch enables, the trigger, busy, done, the count and the overflow flag are low or zero.
- R2: In the idle state, a start pulse latches the three cycle counts and clears the count and the overflow flag. Busy is high from the next cycle, and the clear switch is then held high for the latched clear length. A length of zero is treated as one.
- R3: The first charge holds the charge switch for the charge length, and the resulting code becomes the reference. A second clear follows, and then a second charge of exactly twice the charge length. A charge length of zero is treated as one.
- R4: After each charge or discharge pulse, all switches stay low for the settle time, and then the trigger is high for exactly one cycle. A settle value of zero selects the default of 16 cycles.
- R5: The code is the number of rising clock edges at which the converter enable is high after the trigger. It saturates at 2^CODE_W-1 (255 by default). Quantization ends at the first low sample that follows a high one.
- R6: While the latest code is below the reference, the discharge switch is high for exactly one cycle, the count rises by one, and quantization repeats. No two of the three switches or the trigger are ever high together.
- R7: A code equal to or above the reference ends the measurement. Done is then high for one cycle with busy low, and the count holds until the next accepted start.
- R8: The count saturates at 2^NDC_W-1 (NDC_W is 12 by default). The overflow flag is set when a pulse occurs at the saturated value, and it stays set until the next start.
- R9: A start pulse or a change of the cycle-count inputs during a measurement has no effect on that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a measurement (accepted only when idle) |
| rst_cyc | input | CNT_W | Clear-switch length in cycles |
| chg_cyc | input | CNT_W | First charge length in cycles |
| settle_cyc | input | CNT_W | Settle wait before each trigger, 0 = default |
| conv_en | input | 1 | Enable pulse returned by the converter |
| sw_reset | output | 1 | Node clear switch enable |
| sw_charge | output | 1 | Current-source charge switch enable |
| sw_discharge | output | 1 | Discharge switch enable |
| conv_trig | output | 1 | One-cycle start to the converter |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle end-of-measurement pulse |
| ndc | output | NDC_W | Discharge pulse count |
| ndc_ovf | output | 1 | Count saturated |

## Verification
The hardest condition to reach is count saturation. It needs a node that decays slowly enough to take more discharge steps than the counter can hold, and each step costs a full settle and pulse-width wait. The bench therefore builds the sequencer with a narrow count and drives a decay factor close to one with a short settle time. A second hard case is code saturation with equal codes. It is reached by charging the node so little that both converter pulses run past the code ceiling, so that an ending with zero steps shows the clamp is working.

// File: rtl/tau_meas_pkg.sv
package tau_meas_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_CHG,
      ST_SETTLE,
      ST_TRIG,
      ST_MEAS,
      ST_DSC,
      ST_DONE
   } seq_state_e;
endpackage

// File: rtl/tau_phase_timer.sv
module tau_phase_timer #(
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [LEN_W-1:0] len,
   output logic             fin
);
   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   // len is never zero: the caller clamps it to at least one
   assign fin = (cnt_q == len - 1'b1);
endmodule

// File: rtl/tau_pulse_quant.sv
module tau_pulse_quant #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              measure,
   input  logic              pulse_in,
   output logic [CODE_W-1:0] code,
   output logic              fin
);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code   <= '0;
         seen_q <= 1'b0;
      end else if (clear) begin
         code   <= '0;
         seen_q <= 1'b0;
      end else if (measure && pulse_in) begin
         seen_q <= 1'b1;
         if (code != CODE_MAX) code <= code + 1'b1;
      end
   end

   assign fin = measure && seen_q && !pulse_in;
endmodule

// File: rtl/tau_sat_counter.sv
module tau_sat_counter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count,
   output logic         ovf
);
   localparam logic [W-1:0] MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (inc) begin
         if (count == MAX) ovf <= 1'b1;
         else              count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/tau_meas_seq.sv
module tau_meas_seq
   import tau_meas_pkg::*;
#(
   parameter int CNT_W      = 10,
   parameter int CODE_W     = 8,
   parameter int NDC_W      = 12,
   parameter int DEF_SETTLE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] rst_cyc,
   input  logic [CNT_W-1:0] chg_cyc,
   input  logic [CNT_W-1:0] settle_cyc,
   input  logic             conv_en,
   output logic             sw_reset,
   output logic             sw_charge,
   output logic             sw_discharge,
   output logic             conv_trig,
   output logic             busy,
   output logic             done,
   output logic [NDC_W-1:0] ndc,
   output logic             ndc_ovf
);
   localparam int LEN_W = CNT_W + 1;
   localparam logic [LEN_W-1:0] DEF_LEN = LEN_W'(DEF_SETTLE);

   generate
      if (CNT_W < 2)  begin : g_bad_cnt  $error("CNT_W must be at least 2");  end
      if (CODE_W < 2) begin : g_bad_code $error("CODE_W must be at least 2"); end
      if (NDC_W < 2)  begin : g_bad_ndc  $error("NDC_W must be at least 2");  end
      if (DEF_SETTLE < 1 || DEF_SETTLE >= (1 << CNT_W)) begin : g_bad_set
         $error("DEF_SETTLE must fit in CNT_W and be nonzero");
      end
   endgenerate

   function automatic logic [LEN_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
      return (v == '0) ? LEN_W'(1) : LEN_W'(v);
   endfunction

   seq_state_e        st_q, st_d;
   logic [LEN_W-1:0]  rst_len_q, chg_len_q, set_len_q, t_len;
   logic [CODE_W-1:0] ref_q, code;
   logic              second_q, skip_q;
   logic              t_fin, q_fin, accept;

   assign accept = (st_q == ST_IDLE) && start;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (start) st_d = ST_RST;
         ST_RST:    if (t_fin) st_d = ST_CHG;
         ST_CHG:    if (t_fin) st_d = ST_SETTLE;
         ST_SETTLE: if (t_fin) st_d = ST_TRIG;
         ST_TRIG:   st_d = ST_MEAS;
         ST_MEAS:
            if (q_fin) begin
               if (!skip_q)          st_d = ST_RST;
               else if (code < ref_q) st_d = ST_DSC;
               else                  st_d = ST_DONE;
            end
         ST_DSC:    st_d = ST_SETTLE;
         ST_DONE:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (st_q)
         ST_RST:    t_len = rst_len_q;
         ST_CHG:    t_len = second_q ? (chg_len_q << 1) : chg_len_q;
         ST_SETTLE: t_len = set_len_q;
         default:   t_len = LEN_W'(1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         rst_len_q <= LEN_W'(1);
         chg_len_q <= LEN_W'(1);
         set_len_q <= DEF_LEN;
         ref_q     <= '0;
         second_q  <= 1'b0;
         skip_q    <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            rst_len_q <= at_least_one(rst_cyc);
            chg_len_q <= at_least_one(chg_cyc);
            set_len_q <= (settle_cyc == '0) ? DEF_LEN : LEN_W'(settle_cyc);
            second_q  <= 1'b0;
            skip_q    <= 1'b0;
         end
         if (st_q == ST_MEAS && q_fin && !skip_q) begin
            ref_q    <= code;
            second_q <= 1'b1;
         end
         if (st_q == ST_CHG && t_fin && second_q) skip_q <= 1'b1;
      end
   end

   tau_phase_timer #(.LEN_W(LEN_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (st_d != st_q),
      .len     (t_len),
      .fin     (t_fin)
   );

   tau_pulse_quant #(.CODE_W(CODE_W)) u_quant (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (st_q == ST_TRIG),
      .measure  (st_q == ST_MEAS),
      .pulse_in (conv_en),
      .code     (code),
      .fin      (q_fin)
   );

   tau_sat_counter #(.W(NDC_W)) u_ndc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (st_q == ST_DSC),
      .count (ndc),
      .ovf   (ndc_ovf)
   );

   assign sw_reset     = (st_q == ST_RST);
   assign sw_charge    = (st_q == ST_CHG);
   assign sw_discharge = (st_q == ST_DSC);
   assign conv_trig    = (st_q == ST_TRIG);
   assign busy         = (st_q != ST_IDLE) && (st_q != ST_DONE);
   assign done         = (st_q == ST_DONE);
endmodule

// File: rtl/tau_meas_seq_chk.sv
module tau_meas_seq_chk #(
   parameter int NDC_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             sw_reset,
   input logic             sw_charge,
   input logic             sw_discharge,
   input logic             conv_trig,
   input logic             busy,
   input logic             done,
   input logic [NDC_W-1:0] ndc,
   input logic             ndc_ovf
);
   localparam logic [NDC_W-1:0] NDC_MAX = '1;

   assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> (busy && sw_reset && ndc == '0 && !ndc_ovf));

   assert_trig_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_trig |=> !conv_trig);

   assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sw_reset, sw_charge, sw_discharge, conv_trig}));

   assert_dsc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_discharge |=> !sw_discharge);

   assert_dsc_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_discharge && ndc != NDC_MAX) |=> (ndc == $past(ndc) + 1'b1));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !sw_discharge));

   assert_done_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(ndc));

   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ndc == NDC_MAX) |=> (ndc == NDC_MAX));

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ndc_ovf) |=> ndc_ovf);

   assert_ovf_only_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ndc_ovf) |-> (ndc == NDC_MAX));
endmodule

bind tau_meas_seq tau_meas_seq_chk #(.NDC_W(NDC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .sw_reset     (sw_reset),
   .sw_charge    (sw_charge),
   .sw_discharge (sw_discharge),
   .conv_trig    (conv_trig),
   .busy         (busy),
   .done         (done),
   .ndc          (ndc),
   .ndc_ovf      (ndc_ovf)
);

// File: tb/tau_meas_seq_tb.sv
module tau_meas_seq_tb;
   localparam int CNT_W  = 10;
   localparam int NDC_W  = 6;
   localparam int NDC_MX = (1 << NDC_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] rst_cyc = '0, chg_cyc = '0, settle_cyc = '0;
   logic             conv_en = 1'b0;
   logic             sw_reset, sw_charge, sw_discharge, conv_trig, busy, done, ndc_ovf;
   logic [NDC_W-1:0] ndc;

   always #5 clk = ~clk;

   tau_meas_seq #(.CNT_W(CNT_W), .CODE_W(8), .NDC_W(NDC_W), .DEF_SETTLE(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rst_cyc(rst_cyc), .chg_cyc(chg_cyc),
      .settle_cyc(settle_cyc), .conv_en(conv_en), .sw_reset(sw_reset),
      .sw_charge(sw_charge), .sw_discharge(sw_discharge), .conv_trig(conv_trig),
      .busy(busy), .done(done), .ndc(ndc), .ndc_ovf(ndc_ovf));

   int n_chk = 0, n_bad = 0, cyc = 0;

   // analog node model: integer voltage, linear charge, geometric decay
   int v = 0, i_step = 10, dec = 230, stuck = 0;
   int exp_r, exp_s, rrun, crun, drun, gap, n_chg, n_dsc, bad_r, bad_d, bad_g, n_gap;
   int chg_len[2];
   bit armed;

   function automatic int width_of(input int volt, input int stk);
      int w;
      if (stk > 0) return stk;
      w = 300 - volt / 8;
      if (w < 1) w = 1;
      if (w > 400) w = 400;
      return w;
   endfunction

   function automatic int code_of(input int volt, input int stk);
      int w = width_of(volt, stk);
      return (w > 255) ? 255 : w;
   endfunction

   function automatic int steps_of(input int istep, input int c, input int dk, input int stk);
      int d1 = code_of(istep * c, stk);
      int vv = 2 * istep * c;
      int n = 0;
      while (code_of(vv, stk) < d1 && n < 100000) begin
         vv = vv * dk / 256;
         n++;
      end
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (sw_reset) v = 0;
      else if (sw_charge) v = v + i_step;
      else if (sw_discharge) v = v * dec / 256;
   end

   always begin
      @(negedge clk);
      if (conv_trig) begin
         automatic int w = width_of(v, stuck);
         @(negedge clk);
         conv_en = 1'b1;
         repeat (w) @(negedge clk);
         conv_en = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (sw_reset) rrun++;
      else if (rrun > 0) begin if (rrun != exp_r) bad_r++; rrun = 0; end
      if (sw_charge) crun++;
      else if (crun > 0) begin if (n_chg < 2) chg_len[n_chg] = crun; n_chg++; crun = 0; end
      if (sw_discharge) drun++;
      else if (drun > 0) begin if (drun != 1) bad_d++; n_dsc++; drun = 0; end
      if (sw_reset || sw_charge || sw_discharge) begin gap = 0; armed = 1'b1; end
      else if (conv_trig && armed) begin if (gap != exp_s) bad_g++; n_gap++; armed = 1'b0; end
      else if (armed) gap++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic run(input int r, input int c, input int s, input int ist, input int dk,
                      input int stk, input bit disturb);
      int ce = (c == 0) ? 1 : c;
      int n_exp = steps_of(ist, ce, dk, stk);
      int ndc_exp = (n_exp > NDC_MX) ? NDC_MX : n_exp;
      exp_r = (r == 0) ? 1 : r;
      exp_s = (s == 0) ? 16 : s;
      i_step = ist; dec = dk; stuck = stk;
      rrun = 0; crun = 0; drun = 0; gap = 0; n_chg = 0; n_dsc = 0;
      bad_r = 0; bad_d = 0; bad_g = 0; n_gap = 0; armed = 1'b0;
      chg_len[0] = 0; chg_len[1] = 0;
      rst_cyc = CNT_W'(r); chg_cyc = CNT_W'(c); settle_cyc = CNT_W'(s);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy && sw_reset && ndc == 0 && !ndc_ovf, "R2 start accepted", busy, 1);
      if (disturb) begin
         repeat (5) @(negedge clk);
         rst_cyc = CNT_W'(r + 3); chg_cyc = CNT_W'(c + 7); settle_cyc = CNT_W'(s + 2);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      while (!done) @(negedge clk);
      check(!busy, "R7 busy low with done", busy, 0);
      check(ndc == NDC_W'(ndc_exp), "R6 discharge count", ndc, ndc_exp);
      check(ndc_ovf == (n_exp > NDC_MX), "R8 overflow flag", ndc_ovf, n_exp > NDC_MX);
      check(n_dsc == n_exp, "R6 discharge pulses seen", n_dsc, n_exp);
      check(bad_d == 0, "R6 one-cycle discharge", bad_d, 0);
      check(bad_r == 0, "R2 clear length", bad_r, 0);
      check(chg_len[0] == ce, "R3 first charge", chg_len[0], ce);
      check(chg_len[1] == 2 * ce, "R3 second charge", chg_len[1], 2 * ce);
      check(bad_g == 0 && n_gap == n_exp + 2, "R4 settle gap", bad_g, 0);
      @(negedge clk);
      check(!done, "R7 done single cycle", done, 0);
      repeat (3) @(negedge clk);
      check(ndc == NDC_W'(ndc_exp), "R7 count held", ndc, ndc_exp);
      if (disturb) check(ndc == NDC_W'(ndc_exp) && bad_r == 0, "R9 inputs ignored", ndc, ndc_exp);
      rst_cyc = '0; chg_cyc = '0; settle_cyc = '0;
   endtask

   initial begin
      void'($urandom(32'd7781));
      repeat (3) @(negedge clk);
      check(!sw_reset && !sw_charge && !sw_discharge && !conv_trig, "R1 switches in reset",
            {sw_reset, sw_charge, sw_discharge, conv_trig}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && ndc == 0 && !ndc_ovf, "R1 state after reset", ndc, 0);

      run(3, 40, 4, 10, 230, 0, 1'b0);  // basic
      run(2, 40, 0, 10, 220, 0, 1'b0);  // R4 default settle
      run(0, 0, 1, 8, 230, 0, 1'b0);    // R2/R3 zero lengths
      run(1, 2, 3, 8, 230, 0, 1'b0);    // R5 both codes saturate
      run(2, 40, 3, 10, 230, 100, 1'b0);// R7 equal codes end at once
      run(1, 40, 2, 10, 254, 0, 1'b0);  // R8 overflow
      run(2, 35, 3, 12, 225, 0, 1'b0);  // R8 flag cleared on next start
      run(4, 30, 5, 12, 215, 0, 1'b1);  // R9 disturbance
      for (int k = 0; k < 8; k++)
         run($urandom_range(1, 6), $urandom_range(20, 60), $urandom_range(0, 6),
             $urandom_range(8, 16), $urandom_range(190, 240), 0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule